// File: doc/BRIEF.md
# Staged LED Register Bank with Stop-Qualified Commit

This block sits behind a two-wire serial slave front end and keeps a bank of thirteen 8-bit control registers for an LED driver. The front end hands over one-cycle event pulses: START, repeated START, STOP, an address hit, the acknowledged register-pointer byte and every acknowledged data byte. Each data byte lands in a staging copy of its register in the cycle its acknowledge is given. The thirteen live outputs take the staged values only when a STOP qualifies as a commit.

A STOP commits when staged data is waiting and the current burst is complete. A burst is incomplete from the moment the pointer byte is acknowledged until the first data byte after it is acknowledged. A STOP in that window is dropped, and so is every later STOP until a new data byte arrives. Repeated STARTs aimed at other devices on the bus leave the staged data alone, so one shared STOP can update every device at once. Register 0 carries a broadcast-enable flag. While that flag is set in the live copy, a write to register 1 loads the byte into registers 1 through 12 at once. The flag clears itself when that broadcast is committed.

Top module: `led_shadow_bank`

## Requirements
- R1: A synchronous active-high `rst` clears all staging and live registers to zero and drops any waiting commit. A STOP after reset leaves every output at zero.
- R2: An accepted data byte goes into the staging register in the cycle of its `data_ack` pulse. `live_o` does not change until a commit.
- R3: A STOP that arrives while staged data is waiting and no hold-off is active copies all thirteen staging registers to `live_o`. The new values are visible in the cycle after the `stop_evt` pulse.
- R4: A repeated START with no address hit afterwards keeps the staged data waiting. A later STOP commits it.
- R5: From an accepted pointer byte until the next accepted data byte, every STOP is ignored, including repeated ones. The live values stay unchanged and waiting data stays staged. It commits at the first STOP after a data byte has been accepted.
- R6: The pointer byte sets the target register. The pointer then steps by one after each accepted data byte and saturates at 255. A byte aimed at an index above 12 is discarded.
- R7: While bit 1 of live register 0 is 1, an accepted data byte aimed at index 1 is staged into registers 1 through 12. Register 0 is not touched.
- R8: When a burst that performed a broadcast is committed, bit 1 of register 0 is forced to 0 in both the live and staging copies. A later write to index 1 then touches only register 1.
- R9: Pointer and data pulses are ignored unless an address hit has come since the last START, repeated START or STOP.
- R10: A STOP with nothing staged leaves `live_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_evt | input | 1 | START condition pulse |
| rstart_evt | input | 1 | Repeated START condition pulse |
| stop_evt | input | 1 | STOP condition pulse |
| addr_hit | input | 1 | Own write address acknowledged |
| sub_ack | input | 1 | Pointer byte acknowledged |
| sub_byte | input | 8 | Pointer byte value |
| data_ack | input | 1 | Data byte acknowledged |
| data_byte | input | 8 | Data byte value |
| live_o | output | 104 | Live registers, register i at bits [8i+7:8i] |

## Verification
Every input takes effect at the rising edge where its pulse is high. Staging therefore changes one edge after `data_ack`, and `live_o` changes one edge after a qualifying `stop_evt`. The bench raises each pulse just after a falling edge and lowers it at the next falling edge. It reads `live_o` at that later falling edge, which falls exactly half a cycle after the edge that consumed the pulse. Checks that a value has not changed yet read `live_o` after the last data pulse and before the STOP. Checks that a STOP was ignored read it after that STOP.

// File: rtl/ledbank_pkg.sv
package ledbank_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned PTR_W  = 8;

    typedef enum logic [1:0] {
        LNK_IDLE,
        LNK_ADDRESSED,
        LNK_POINTED
    } link_state_e;

    typedef struct packed {
        logic              we;
        logic              bcast;
        logic [PTR_W-1:0]  idx;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic logic idx_in_bank(input logic [PTR_W-1:0] idx, input int unsigned n);
        return (32'(idx) < n);
    endfunction

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        return (p == {PTR_W{1'b1}}) ? p : p + 1'b1;
    endfunction

endpackage

// File: rtl/burst_tracker.sv
module burst_tracker
    import ledbank_pkg::*;
#(
    parameter int unsigned NUM_REGS  = 13,
    parameter int unsigned BCAST_IDX = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              any_start,
    input  logic              stop_evt,
    input  logic              addr_hit,
    input  logic              sub_ack,
    input  logic [PTR_W-1:0]  sub_byte,
    input  logic              data_ack,
    input  logic [BYTE_W-1:0] data_byte,
    input  logic              bcast_en,
    output wr_req_t           wr_o,
    output logic              commit_o,
    output logic              hold_off_o
);
    link_state_e      state_q;
    logic [PTR_W-1:0] ptr_q;
    logic             hold_off_q;
    logic             pending_q;
    logic             sub_take;
    logic             data_take;

    assign sub_take  = sub_ack  && (state_q == LNK_ADDRESSED);
    assign data_take = data_ack && (state_q == LNK_POINTED);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LNK_IDLE;
            ptr_q   <= '0;
        end else if (any_start || stop_evt) begin
            state_q <= LNK_IDLE;
        end else if (addr_hit) begin
            state_q <= LNK_ADDRESSED;
        end else if (sub_take) begin
            state_q <= LNK_POINTED;
            ptr_q   <= sub_byte;
        end else if (data_take) begin
            ptr_q   <= ptr_step(ptr_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_off_q <= 1'b0;
            pending_q  <= 1'b0;
        end else begin
            if (sub_take)       hold_off_q <= 1'b1;
            else if (data_take) hold_off_q <= 1'b0;
            if (data_take)      pending_q  <= 1'b1;
            else if (commit_o)  pending_q  <= 1'b0;
        end
    end

    assign commit_o   = stop_evt && pending_q && !hold_off_q;
    assign hold_off_o = hold_off_q;

    always_comb begin
        wr_o.we    = data_take && idx_in_bank(ptr_q, NUM_REGS);
        wr_o.bcast = wr_o.we && bcast_en && (ptr_q == PTR_W'(BCAST_IDX));
        wr_o.idx   = ptr_q;
        wr_o.data  = data_byte;
    end

    // R6: pointer advances by one per accepted data byte
    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (rst)
        (data_take && !any_start && !stop_evt && !addr_hit && ptr_q != {PTR_W{1'b1}})
            |=> (ptr_q == $past(ptr_q) + 1'b1));

    // R9: data is never written while not addressed
    assert_no_write_unaddressed_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q != LNK_POINTED) |-> !wr_o.we);

endmodule

// File: rtl/shadow_regs.sv
module shadow_regs
    import ledbank_pkg::*;
#(
    parameter int unsigned NUM_REGS = 13,
    parameter int unsigned FLAG_BIT = 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  wr_req_t                        wr_i,
    input  logic                           commit_i,
    output logic [NUM_REGS-1:0][BYTE_W-1:0] live_o,
    output logic                           bcast_en_o
);
    localparam logic [BYTE_W-1:0] FLAG_MASK = BYTE_W'(1) << FLAG_BIT;

    logic [NUM_REGS-1:0][BYTE_W-1:0] stage_q;
    logic [NUM_REGS-1:0][BYTE_W-1:0] live_q;
    logic                            bcast_pend_q;

    always_ff @(posedge clk) begin
        if (rst)                    bcast_pend_q <= 1'b0;
        else if (wr_i.bcast)        bcast_pend_q <= 1'b1;
        else if (commit_i)          bcast_pend_q <= 1'b0;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic hit;
        if (g == 0) begin : g_ctl
            assign hit = wr_i.we && (wr_i.idx == PTR_W'(0));
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[g] <= '0;
                    live_q[g]  <= '0;
                end else if (commit_i) begin
                    if (bcast_pend_q) begin
                        stage_q[g] <= stage_q[g] & ~FLAG_MASK;
                        live_q[g]  <= stage_q[g] & ~FLAG_MASK;
                    end else begin
                        live_q[g]  <= stage_q[g];
                    end
                end else if (hit) begin
                    stage_q[g] <= wr_i.data;
                end
            end
        end else begin : g_led
            assign hit = wr_i.we && (wr_i.bcast || (wr_i.idx == PTR_W'(g)));
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[g] <= '0;
                    live_q[g]  <= '0;
                end else if (commit_i) begin
                    live_q[g]  <= stage_q[g];
                end else if (hit) begin
                    stage_q[g] <= wr_i.data;
                end
            end
        end
    end

    assign live_o     = live_q;
    assign bcast_en_o = live_q[0][FLAG_BIT];

    // R1: reset empties the live bank
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (live_q == '0));

    // R3: live values move only on a commit (or reset)
    assert_live_only_on_commit_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(live_q) |-> ($past(commit_i) || $past(rst)));

    // R8: broadcast flag is consumed by the committing STOP
    assert_flag_consumed_R8: assert property (@(posedge clk) disable iff (rst)
        (commit_i && bcast_pend_q) |=> !live_q[0][FLAG_BIT]);

endmodule

// File: rtl/led_shadow_bank.sv
module led_shadow_bank
    import ledbank_pkg::*;
#(
    parameter int unsigned NUM_REGS  = 13,
    parameter int unsigned FLAG_BIT  = 1,
    parameter int unsigned BCAST_IDX = 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start_evt,
    input  logic                       rstart_evt,
    input  logic                       stop_evt,
    input  logic                       addr_hit,
    input  logic                       sub_ack,
    input  logic [7:0]                 sub_byte,
    input  logic                       data_ack,
    input  logic [7:0]                 data_byte,
    output logic [NUM_REGS*8-1:0]      live_o
);
    wr_req_t                         wr;
    logic                            commit;
    logic                            hold_off;
    logic                            bcast_en;
    logic [NUM_REGS-1:0][BYTE_W-1:0] live;

    burst_tracker #(.NUM_REGS(NUM_REGS), .BCAST_IDX(BCAST_IDX)) u_track (
        .clk        (clk),
        .rst        (rst),
        .any_start  (start_evt || rstart_evt),
        .stop_evt   (stop_evt),
        .addr_hit   (addr_hit),
        .sub_ack    (sub_ack),
        .sub_byte   (sub_byte),
        .data_ack   (data_ack),
        .data_byte  (data_byte),
        .bcast_en   (bcast_en),
        .wr_o       (wr),
        .commit_o   (commit),
        .hold_off_o (hold_off)
    );

    shadow_regs #(.NUM_REGS(NUM_REGS), .FLAG_BIT(FLAG_BIT)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (wr),
        .commit_i   (commit),
        .live_o     (live),
        .bcast_en_o (bcast_en)
    );

    assign live_o = live;

    // R5: a STOP inside an unfinished burst leaves the outputs alone
    assert_stop_held_off_R5: assert property (@(posedge clk) disable iff (rst)
        (stop_evt && hold_off) |=> $stable(live_o));

endmodule

// File: tb/led_shadow_bank_test.sv
module led_shadow_bank_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_evt, rstart_evt, stop_evt, addr_hit, sub_ack, data_ack;
    logic [7:0]  sub_byte, data_byte;
    logic [103:0] live_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [7:0] exp_r [13];

    always #5 clk = ~clk;

    led_shadow_bank uut (
        .clk(clk), .rst(rst), .start_evt(start_evt), .rstart_evt(rstart_evt),
        .stop_evt(stop_evt), .addr_hit(addr_hit), .sub_ack(sub_ack),
        .sub_byte(sub_byte), .data_ack(data_ack), .data_byte(data_byte),
        .live_o(live_o)
    );

    function automatic logic [7:0] rd(input int i);
        return live_o[i*8 +: 8];
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic chk_bank(input string tag);
        for (int i = 0; i < 13; i++) chk($sformatf("%s reg%0d", tag, i), rd(i), exp_r[i]);
    endtask

    task automatic p_start();  @(negedge clk); start_evt = 1;  @(negedge clk); start_evt = 0;  endtask
    task automatic p_rstart(); @(negedge clk); rstart_evt = 1; @(negedge clk); rstart_evt = 0; endtask
    task automatic p_stop();   @(negedge clk); stop_evt = 1;   @(negedge clk); stop_evt = 0;   endtask
    task automatic p_addr();   @(negedge clk); addr_hit = 1;   @(negedge clk); addr_hit = 0;   endtask
    task automatic p_sub(input logic [7:0] b);
        @(negedge clk); sub_ack = 1; sub_byte = b; @(negedge clk); sub_ack = 0;
    endtask
    task automatic p_data(input logic [7:0] b);
        @(negedge clk); data_ack = 1; data_byte = b; @(negedge clk); data_ack = 0;
    endtask
    task automatic open_at(input logic [7:0] idx);
        p_start(); p_addr(); p_sub(idx);
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1; repeat (2) @(negedge clk); rst = 0;
        for (int i = 0; i < 13; i++) exp_r[i] = 8'h00;
        chk_bank("R1 after reset");
        p_stop();
        chk_bank("R10 stop with nothing staged");
    endtask

    task automatic t_basic();
        open_at(8'd3); p_data(8'hA1); p_data(8'hB2);
        chk_bank("R2 staged but not live");
        p_stop();
        exp_r[3] = 8'hA1; exp_r[4] = 8'hB2;
        chk_bank("R3 R6 commit with auto-increment");
        p_stop();
        chk_bank("R10 second stop no change");
    endtask

    task automatic t_range();
        open_at(8'd12); p_data(8'h11); p_data(8'h22); p_data(8'h33); p_stop();
        exp_r[12] = 8'h11;
        chk_bank("R6 out-of-range bytes discarded");
        open_at(8'd200); p_data(8'h44); p_stop();
        chk_bank("R6 pointer above 12 discarded");
    endtask

    task automatic t_rstart();
        open_at(8'd5); p_data(8'h5C);
        p_rstart();
        chk("R4 held across repeated start", rd(5), 8'h00);
        p_stop();
        exp_r[5] = 8'h5C;
        chk_bank("R4 global stop commits");
    endtask

    task automatic t_premature();
        open_at(8'd7); p_data(8'h77);
        p_rstart(); p_addr(); p_sub(8'd8);
        p_stop();
        chk_bank("R5 premature stop ignored");
        p_stop();
        chk_bank("R5 repeated stop still ignored");
        open_at(8'd8); p_data(8'h88); p_stop();
        exp_r[7] = 8'h77; exp_r[8] = 8'h88;
        chk_bank("R5 full burst commits both");
    endtask

    task automatic t_unaddressed();
        p_start(); p_sub(8'd9); p_data(8'h99); p_stop();
        chk_bank("R9 unaddressed strobes ignored");
        p_start(); p_addr(); p_start(); p_sub(8'd9); p_data(8'h9A); p_stop();
        chk_bank("R9 start drops address hit");
    endtask

    task automatic t_quick();
        open_at(8'd0); p_data(8'h02); p_stop();
        exp_r[0] = 8'h02;
        chk("R7 flag set live", rd(0), 8'h02);
        open_at(8'd1); p_data(8'h5A);
        chk_bank("R2 broadcast not live before stop");
        p_stop();
        for (int i = 1; i < 13; i++) exp_r[i] = 8'h5A;
        exp_r[0] = 8'h00;
        chk_bank("R7 R8 broadcast committed, flag consumed");
        open_at(8'd1); p_data(8'h33); p_stop();
        exp_r[1] = 8'h33;
        chk_bank("R8 next write to reg1 is single");
    endtask

    task automatic t_reset_pending();
        open_at(8'd2); p_data(8'hEE);
        @(negedge clk); rst = 1; @(negedge clk); rst = 0;
        for (int i = 0; i < 13; i++) exp_r[i] = 8'h00;
        p_stop();
        chk_bank("R1 reset drops staged data");
    endtask

    initial begin
        rst = 1; start_evt = 0; rstart_evt = 0; stop_evt = 0; addr_hit = 0;
        sub_ack = 0; data_ack = 0; sub_byte = 0; data_byte = 0;
        t_reset();
        t_basic();
        t_range();
        t_rstart();
        t_premature();
        t_unaddressed();
        t_quick();
        t_reset_pending();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule